// File: doc/BRIEF.md
# Dual-Lane Truncating Double-to-Int32 Converter

This block turns a 128-bit operand carrying two IEEE-754 binary64 values into two 32-bit two's-complement integers. It always rounds toward zero and does not depend on any rounding mode. The two integers are packed into one 64-bit result word. Each lane classifies its input. NaN, infinity, or a truncated magnitude outside the signed 32-bit range makes the lane invalid, and an invalid lane is replaced by the indefinite integer 0x8000_0000.

The block also reports status for the whole operation. The invalid flag is set if either lane is invalid. The inexact flag is set if a valid lane threw away a nonzero fraction. A trap indication is raised when an invalid lane occurs while the invalid mask input is low, and in that case the write enable for the entire 64-bit result is held low. No condition flags are produced.

A single register stage with valid/ready handshakes on both sides separates the combinational lanes from the output. A result appears one cycle after its operand is accepted.

Top module: `f64x2_to_i32_trunc`

## Requirements
- R1: Lane 0 takes operand bits 63:0 and writes result bits 31:0. Lane 1 takes operand bits 127:64 and writes result bits 63:32.
- R2: A finite value in range is converted with its fraction discarded toward zero, for both signs (2.75 gives 2, -2.75 gives 0xFFFFFFFE, 0.5 gives 0).
- R3: Zero of either sign and subnormal inputs of either sign give 0. A subnormal sets out_inexact and zero does not.
- R4: A NaN (biased exponent all ones, nonzero fraction) or an infinity of either sign makes its lane invalid. The lane's result field is 0x80000000 and out_invalid is high.
- R5: Inputs whose truncated value is +2^31 or more are invalid. Inputs in (-2^31-1, -2^31] give 0x80000000 and are valid. Inputs at or below -2^31-1 are invalid.
- R6: out_inexact is high exactly when at least one valid lane discarded a nonzero fraction. Invalid lanes never contribute to it.
- R7: When in_inv_mask (sampled with the operand) is low and either lane is invalid, out_trap is high and out_wr_en is low. Otherwise out_trap is low and out_wr_en equals out_valid.
- R8: An operand is accepted on a rising edge where in_valid and in_ready are both high. Its result is presented with out_valid high after that edge. in_ready equals (not out_valid) or out_ready.
- R9: While out_valid is high and out_ready is low, the presented result and status remain unchanged and out_valid stays high.
- R10: A synchronous active-high reset clears out_valid, so in_ready is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Stage can take an operand |
| in_operand | input | 128 | Two binary64 values, lane 1 in the upper half |
| in_inv_mask | input | 1 | High: invalid lanes yield indefinite without trap |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Two packed int32 results, lane 1 in the upper half |
| out_wr_en | output | 1 | Result may be written |
| out_invalid | output | 1 | At least one lane invalid |
| out_inexact | output | 1 | A valid lane lost a nonzero fraction |
| out_trap | output | 1 | Unmasked invalid operation |

## Verification
The conversion is tried with exact small integers, positive and negative fractional values, signed zeros, subnormals and values below one. These separate truncation from rounding to nearest and show whether the sign is handled correctly on negation. Operands sit on both sides of each range edge: 2^31-1, 2^31-0.5, 2^31, 2^31+0.5, -2^31, -2^31-0.5 and -2^31-1. They show whether the range test looks at the integer part or at the raw exponent. Some vectors pair NaN or infinity in one lane with an inexact valid value in the other. These tell lane placement apart, show how the status flags merge across lanes, and show that an invalid lane's fraction is kept out of the inexact flag. Both mask settings are exercised against the trap and write-enable outputs.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

   // Per-lane status produced by the converter
   typedef struct packed {
      logic invalid;
      logic inexact;
   } lane_flags_t;

   // Classification of one floating-point input
   typedef enum logic [2:0] {
      CL_ZERO = 3'd0,  // zero or subnormal
      CL_FRAC = 3'd1,  // normal, magnitude below one
      CL_NORM = 3'd2,  // fully representable integer part
      CL_EDGE = 3'd3,  // exponent at the negative range limit
      CL_BAD  = 3'd4   // NaN, infinity or out of range
   } fp_class_t;

endpackage

// File: rtl/f2i_lane.sv
module f2i_lane #(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   parameter int INT_W = 32
) (
   input  logic [EXP_W+MAN_W:0]  fp_in,
   output logic [INT_W-1:0]      int_out,
   output f2i_pkg::lane_flags_t  flags
);
   import f2i_pkg::*;

   localparam int SIG_W  = MAN_W + 1;
   localparam int SH_W   = $clog2(SIG_W) + 1;
   localparam int MAG_W  = INT_W - 1;
   localparam int E_W    = EXP_W + 2;
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
   localparam logic signed [E_W-1:0] BIAS_V = E_W'(BIAS);
   localparam logic signed [E_W-1:0] E_TOP  = E_W'(INT_W - 2);
   localparam logic signed [E_W-1:0] E_EDGE = E_W'(INT_W - 1);
   localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

   generate
      if (MAN_W < INT_W) begin : g_bad_man
         $error("f2i_lane: MAN_W must be at least INT_W");
      end
      if (INT_W < 2) begin : g_bad_int
         $error("f2i_lane: INT_W must be at least 2");
      end
      if (SH_W > E_W) begin : g_bad_sh
         $error("f2i_lane: exponent too narrow for shift width");
      end
   endgenerate

   logic                    sgn;
   logic [EXP_W-1:0]        ex;
   logic [MAN_W-1:0]        mn;
   logic signed [E_W-1:0]   e_unb;
   logic [SIG_W-1:0]        sig;
   logic [SH_W-1:0]         sh;
   logic [MAG_W-1:0]        mag;
   logic                    lost;
   logic [INT_W-2:0]        mn_hi;
   logic [MAN_W-INT_W:0]    mn_lo;
   fp_class_t               cls;

   assign sgn   = fp_in[EXP_W+MAN_W];
   assign ex    = fp_in[EXP_W+MAN_W-1:MAN_W];
   assign mn    = fp_in[MAN_W-1:0];
   assign e_unb = $signed({2'b00, ex}) - BIAS_V;
   assign sig   = {1'b1, mn};
   assign sh    = SH_W'(MAN_W) - e_unb[SH_W-1:0];
   assign mag   = MAG_W'(sig >> sh);
   assign lost  = |(sig << (SH_W'(SIG_W) - sh));
   assign mn_hi = mn[MAN_W-1 -: INT_W-1];
   assign mn_lo = mn[MAN_W-INT_W:0];

   // Input classification
   always_comb begin
      if (&ex)
         cls = CL_BAD;
      else if (ex == '0)
         cls = CL_ZERO;
      else if (e_unb[E_W-1])
         cls = CL_FRAC;
      else if (e_unb <= E_TOP)
         cls = CL_NORM;
      else if ((e_unb == E_EDGE) && sgn && (mn_hi == '0))
         cls = CL_EDGE;
      else
         cls = CL_BAD;
   end

   // Result and flag generation per class
   always_comb begin
      int_out       = '0;
      flags.invalid = 1'b0;
      flags.inexact = 1'b0;
      case (cls)
         CL_ZERO: flags.inexact = |mn;
         CL_FRAC: flags.inexact = 1'b1;
         CL_NORM: begin
            int_out       = sgn ? (INT_W'(0) - {1'b0, mag}) : {1'b0, mag};
            flags.inexact = lost;
         end
         CL_EDGE: begin
            int_out       = INDEF;
            flags.inexact = |mn_lo;
         end
         default: begin
            int_out       = INDEF;
            flags.invalid = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/f2i_status_merge.sv
module f2i_status_merge #(
   parameter int LANES = 2
) (
   input  f2i_pkg::lane_flags_t [LANES-1:0] lane_fl,
   input  logic                             inv_mask,
   output logic                             any_invalid,
   output logic                             any_inexact,
   output logic                             trap
);
   always_comb begin
      any_invalid = 1'b0;
      any_inexact = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         any_invalid = any_invalid | lane_fl[i].invalid;
         any_inexact = any_inexact | (lane_fl[i].inexact & ~lane_fl[i].invalid);
      end
   end

   assign trap = any_invalid & ~inv_mask;

endmodule

// File: rtl/f2i_pipe_reg.sv
module f2i_pipe_reg #(
   parameter int W             = 8,
   parameter bit RESET_PAYLOAD = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   logic         vld_q;
   logic [W-1:0] dat_q;
   logic         take;

   assign in_ready  = ~vld_q | out_ready;
   assign take      = in_valid & in_ready;
   assign out_valid = vld_q;
   assign out_data  = dat_q;

   always_ff @(posedge clk) begin
      if (rst)
         vld_q <= 1'b0;
      else if (in_ready)
         vld_q <= in_valid;
   end

   generate
      if (RESET_PAYLOAD) begin : g_rst_data
         always_ff @(posedge clk) begin
            if (rst)
               dat_q <= '0;
            else if (take)
               dat_q <= in_data;
         end
      end else begin : g_free_data
         always_ff @(posedge clk) begin
            if (take)
               dat_q <= in_data;
         end
      end
   endgenerate

endmodule

// File: rtl/f64x2_to_i32_trunc.sv
module f64x2_to_i32_trunc #(
   parameter int LANES         = 2,
   parameter int EXP_W         = 11,
   parameter int MAN_W         = 52,
   parameter int INT_W         = 32,
   parameter bit RESET_PAYLOAD = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic [LANES*(EXP_W+MAN_W+1)-1:0] in_operand,
   input  logic                        in_inv_mask,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic [LANES*INT_W-1:0]      out_result,
   output logic                        out_wr_en,
   output logic                        out_invalid,
   output logic                        out_inexact,
   output logic                        out_trap
);
   localparam int FP_W  = EXP_W + MAN_W + 1;
   localparam int OUT_W = LANES * INT_W;
   localparam int PAY_W = OUT_W + 3;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("f64x2_to_i32_trunc: LANES must be positive");
      end
   endgenerate

   f2i_pkg::lane_flags_t [LANES-1:0] lane_fl;
   logic [OUT_W-1:0] res_comb;
   logic             any_inv, any_inx, trap_c;
   logic [PAY_W-1:0] pay_d, pay_q;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         f2i_lane #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W),
            .INT_W (INT_W)
         ) u_lane (
            .fp_in   (in_operand[g*FP_W +: FP_W]),
            .int_out (res_comb[g*INT_W +: INT_W]),
            .flags   (lane_fl[g])
         );
      end
   endgenerate

   f2i_status_merge #(
      .LANES (LANES)
   ) u_merge (
      .lane_fl     (lane_fl),
      .inv_mask    (in_inv_mask),
      .any_invalid (any_inv),
      .any_inexact (any_inx),
      .trap        (trap_c)
   );

   assign pay_d = {trap_c, any_inx, any_inv, res_comb};

   f2i_pipe_reg #(
      .W             (PAY_W),
      .RESET_PAYLOAD (RESET_PAYLOAD)
   ) u_stage (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (pay_d),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (pay_q)
   );

   assign out_result  = pay_q[OUT_W-1:0];
   assign out_invalid = pay_q[OUT_W];
   assign out_inexact = pay_q[OUT_W+1];
   assign out_trap    = pay_q[OUT_W+2];
   assign out_wr_en   = out_valid & ~pay_q[OUT_W+2];

endmodule

// File: rtl/f2i_chk.sv
module f2i_chk #(
   parameter int OUT_W = 64
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OUT_W-1:0] out_result,
   input logic             out_wr_en,
   input logic             out_invalid,
   input logic             out_inexact,
   input logic             out_trap
);
   // R8
   accept_lat_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);

   // R8
   ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
         && $stable(out_invalid) && $stable(out_inexact) && $stable(out_trap)));

   // R7
   trap_src_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_trap) |-> (out_invalid && !out_wr_en));

   // R7
   wr_ok_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_invalid) |-> out_wr_en);

   // R10
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> !out_valid);

endmodule

bind f64x2_to_i32_trunc f2i_chk #(.OUT_W(LANES*INT_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_result  (out_result),
   .out_wr_en   (out_wr_en),
   .out_invalid (out_invalid),
   .out_inexact (out_inexact),
   .out_trap    (out_trap)
);

// File: tb/sim_f64x2_to_i32_trunc.sv
`timescale 1ns/1ps
module sim_f64x2_to_i32_trunc;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_operand = '0;
   logic         in_inv_mask = 1'b1;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [63:0]  out_result;
   logic         out_wr_en, out_invalid, out_inexact, out_trap;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   always #10 clk = ~clk;

   f64x2_to_i32_trunc u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_operand(in_operand), .in_inv_mask(in_inv_mask),
      .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
      .out_wr_en(out_wr_en), .out_invalid(out_invalid),
      .out_inexact(out_inexact), .out_trap(out_trap)
   );

   localparam int NV = 14;
   // {lane1, lane0}
   localparam logic [127:0] OPS [NV] = '{
      {64'h4008000000000000, 64'h3FF0000000000000},
      {64'hC006000000000000, 64'h4006000000000000},
      {64'h8000000000000000, 64'h0000000000000001},
      {64'h8000000000000000, 64'h3FE0000000000000},
      {64'h0000000000000000, 64'hBFF0000000000000},
      {64'h7FF0000000000000, 64'h7FF8000000000000},
      {64'h41DFFFFFFFC00000, 64'hC1E0000000000000},
      {64'h41E0000000000000, 64'h405EC00000000000},
      {64'hC1E0000000100000, 64'h41DFFFFFFFE00000},
      {64'hC1E0000000200000, 64'h4006000000000000},
      {64'h41E0000000100000, 64'h3FF0000000000000},
      {64'h7FF8000000000000, 64'h4006000000000000},
      {64'h3FF0000000000000, 64'h3FF0000000000000},
      {64'hFFF0000000000000, 64'h3FF0000000000000}
   };
   localparam bit MSK [NV] = '{1,1,1,1,1,1,1,1,1,1,1,0,0,1};
   localparam logic [63:0] EXP_R [NV] = '{
      64'h00000003_00000001, 64'hFFFFFFFE_00000002, 64'h00000000_00000000,
      64'h00000000_00000000, 64'h00000000_FFFFFFFF, 64'h80000000_80000000,
      64'h7FFFFFFF_80000000, 64'h80000000_0000007B, 64'h80000000_7FFFFFFF,
      64'h80000000_00000002, 64'h80000000_00000001, 64'h80000000_00000002,
      64'h00000001_00000001, 64'h80000000_00000001
   };
   // {invalid, inexact, trap, wr_en}
   localparam logic [3:0] EXP_F [NV] = '{
      4'b0001, 4'b0101, 4'b0101, 4'b0101, 4'b0001, 4'b1001, 4'b0001,
      4'b1001, 4'b0101, 4'b1101, 4'b1001, 4'b1110, 4'b0001, 4'b1001
   };

   function automatic string vtag(int i);
      case (i)
         0:       return "R1";
         1, 3, 4: return "R2";
         2:       return "R3";
         5, 13:   return "R4";
         6, 7, 8: return "R5";
         9, 10:   return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
   endtask

   // Watchdog
   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R8 watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R10: reset state
      check("R10", "out_valid after reset", {63'b0, out_valid}, 64'd0);
      check("R10", "in_ready after reset", {63'b0, in_ready}, 64'd1);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         in_operand  = OPS[i];
         in_inv_mask = MSK[i];
         in_valid    = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         check("R8", "out_valid after accept", {63'b0, out_valid}, 64'd1);
         check(vtag(i), $sformatf("result vec %0d", i), out_result, EXP_R[i]);
         check(vtag(i), $sformatf("flags vec %0d", i),
               {60'b0, out_invalid, out_inexact, out_trap, out_wr_en},
               {60'b0, EXP_F[i]});
         @(negedge clk);
      end

      // Backpressure: hold result while consumer stalls
      out_ready   = 1'b0;
      in_operand  = OPS[0];
      in_inv_mask = 1'b1;
      in_valid    = 1'b1;
      @(negedge clk);
      check("R8", "in_ready low when full and stalled", {63'b0, in_ready}, 64'd0);
      in_operand = OPS[1];
      @(negedge clk);
      check("R9", "stalled out_valid", {63'b0, out_valid}, 64'd1);
      check("R9", "stalled result unchanged", out_result, EXP_R[0]);
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R8", "pass-through result after stall", out_result, EXP_R[1]);
      @(negedge clk);
      check("R8", "drained out_valid", {63'b0, out_valid}, 64'd0);

      // Reset while a result is held
      out_ready  = 1'b0;
      in_operand = OPS[5];
      in_valid   = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R10", "held before reset", {63'b0, out_valid}, 64'd1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R10", "out_valid cleared by reset", {63'b0, out_valid}, 64'd0);
      check("R10", "in_ready after mid reset", {63'b0, in_ready}, 64'd1);
      out_ready = 1'b1;

      done = 1'b1;
      summary();
      $finish;
   end

endmodule